// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a single-port synchronous static memory with a 32-bit data word split into four byte lanes. Its depth is set by a parameter. Every control, address and write-data input is captured on the rising clock edge. Reads pass through one more register on the output side, so read data appears one full cycle after the command was captured. Writes are self-timed: the array is updated on the edge after the command was captured, and no external write pulse is needed.

An access opens when either of two address strobes is low and the three chip selects all agree that the device is selected. An internal two-bit wrapping counter then walks through a four-word group. It steps in linear order or in an exclusive-or (interleaved) order, chosen by a static mode pin. The counter advances on cycles where the advance input is low and no strobe is present. The bus is modelled as a separate data input, a data output and a drive-enable output. The drive enable combines the registered read-valid state with an asynchronous output-enable pin, so a deselected or writing device never drives the bus. No part of this interface carries a data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level-sampled control or data pin.

Top module: `pbsram_core`

## Requirements
- R1: A read command captured on clock edge k places the word at the access address on `dq_o`, with `dq_en` high (when `oe_n` is low), in the cycle that follows edge k+1.
- R2: With `wr_all_n` high and `wr_byte_en_n` low, a write updates only the lanes whose `wr_lane_n[i]` is 0, where lane i is `dq` bits 8*i+7 down to 8*i. All other lanes keep their old contents.
- R3: With `wr_all_n` low, all four lanes are written, whatever the values of `wr_byte_en_n` and `wr_lane_n`.
- R4: A strobe captured while the device is not selected starts no access. The selected condition is `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Such a strobe writes nothing, and the following continuation cycles are ignored until a strobe arrives with the device selected.
- R5: `oe_n` acts asynchronously. While it is high, `dq_en` is 0. Lowering it during a cycle that holds read data raises `dq_en` in that same cycle, with no clock edge needed.
- R6: The output is masked during the first clock of a read that follows a deselected, idle or write cycle. In the cycle right after the new read is captured, `dq_en` stays 0 even with `oe_n` low.
- R7: Either strobe opens an access at `addr`, and the burst count is set to 0. If `start_cpu_n` is low, the opening cycle is a read regardless of the write controls. If only `start_ctl_n` is low, the opening cycle writes when the write controls request it.
- R8: With `burst_ilv`=0, each continuation cycle with `burst_adv_n` low moves the low two address bits to (start + n) mod 4, where n is the number of advances. The upper address bits are unchanged.
- R9: With `burst_ilv`=1, each advance sets the low two address bits to start XOR n, with n counted mod 4.
- R10: A continuation cycle with `burst_adv_n` high repeats the current address. Continuation cycles may write as well as read.
- R11: A read captured on the edge right after a write to the same address returns the newly written data.
- R12: After reset, `dq_en` is 0 and no access is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | AW | Word address, captured when a strobe opens an access |
| start_cpu_n | input | 1 | Active-low strobe that opens an access; the opening cycle is always a read |
| start_ctl_n | input | 1 | Active-low strobe that opens an access; the opening cycle may write |
| burst_adv_n | input | 1 | Active-low advance of the burst counter on continuation cycles |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| wr_all_n | input | 1 | Active-low write of all four lanes |
| wr_byte_en_n | input | 1 | Active-low enable that qualifies the per-lane selects |
| wr_lane_n | input | 4 | Active-low per-lane write selects, bit i for lane i |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_i | input | 32 | Write data, captured with the command |
| dq_o | output | 32 | Read data from the output register |
| dq_en | output | 1 | Bus drive enable; 0 means the bus is in high impedance |

## Verification
On every cycle, the assertions check several things. The output enable is forced off whenever the pin is high. Any registered command other than a read leaves the bus undriven on the next cycle, which covers both the post-deselect mask and write cycles. A strobe without chip select opens nothing. The burst counter either reloads with the strobe address, steps by one, or holds still. Two things can only be shown by the bench scenarios: the data itself and the address sequence the counter produces. These include the byte-lane merging, the global-write override, the read-only behaviour of the processor strobe, write-then-read ordering, and the linear and interleaved visiting orders across wrap-around. The bench shows all of these by reading back words against its own memory model.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low two address bits for a given start offset and advance count.
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] n,
                                          input logic       ilv);
    return ilv ? (start ^ n) : (start + n);
  endfunction

endpackage

// File: rtl/pbsram_cmd.sv
module pbsram_cmd
  import pbsram_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cpu_n,
  input  logic             start_ctl_n,
  input  logic             burst_adv_n,
  input  logic             cs_ok,
  input  logic             wr_all_n,
  input  logic             wr_byte_en_n,
  input  logic [LANES-1:0] wr_lane_n,
  input  logic [DW-1:0]    dq_i,
  output logic             start,
  output logic             acc_go,
  output logic             adv_go,
  output op_e              op_q,
  output logic [LANES-1:0] wmask_q,
  output logic [DW-1:0]    wdata_q
);

  logic             sel_q;
  logic [LANES-1:0] wr_mask;
  logic             wr_any;
  op_e              op_d;

  assign start  = !start_cpu_n || !start_ctl_n;
  assign acc_go = start && cs_ok;
  assign adv_go = !start && sel_q && !burst_adv_n;

  // Lane mask: global write wins over the per-lane selects.
  always_comb begin
    if (!wr_all_n)          wr_mask = '1;
    else if (!wr_byte_en_n) wr_mask = ~wr_lane_n;
    else                    wr_mask = '0;
    wr_any = |wr_mask;
  end

  always_comb begin
    op_d = OP_NONE;
    if (start) begin
      if (cs_ok) begin
        if (!start_cpu_n) op_d = OP_RD;
        else              op_d = wr_any ? OP_WR : OP_RD;
      end
    end else if (sel_q) begin
      op_d = wr_any ? OP_WR : OP_RD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      op_q    <= OP_NONE;
      wmask_q <= '0;
    end else begin
      if (start) sel_q <= cs_ok;
      op_q    <= op_d;
      wmask_q <= wr_mask;
    end
  end

  always_ff @(posedge clk) begin
    wdata_q <= dq_i;
  end

endmodule

// File: rtl/pbsram_burst.sv
module pbsram_burst
  import pbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          ilv,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] base_q,
  output logic [1:0]    cnt_q,
  output logic [AW-1:0] eff_addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= addr;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  assign eff_addr = {base_q[AW-1:2], burst_lo(base_q[1:0], cnt_q, ilv)};

endmodule

// File: rtl/pbsram_array.sv
module pbsram_array #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int LANES = DW / 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] wmask,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_q
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] lane_q;

    always_ff @(posedge clk) begin
      if (we && wmask[g]) mem[addr] <= wdata[g*8 +: 8];
      if (re)             lane_q    <= mem[addr];
    end

    assign rd_q[g*8 +: 8] = lane_q;
  end

endmodule

// File: rtl/pbsram_out.sv
module pbsram_out
  import pbsram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  op_q,
  input  logic oe_n,
  output logic dq_en
);

  logic live_q;

  // Set only by a read one stage back, so the first clock of any read
  // after a non-read cycle is masked regardless of the output enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= (op_q == OP_RD);
  end

  assign dq_en = live_q && !oe_n;

endmodule

// File: rtl/pbsram_core.sv
module pbsram_core
  import pbsram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int LANES = DW / 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             start_cpu_n,
  input  logic             start_ctl_n,
  input  logic             burst_adv_n,
  input  logic             burst_ilv,
  input  logic             wr_all_n,
  input  logic             wr_byte_en_n,
  input  logic [LANES-1:0] wr_lane_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             oe_n,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_en
);

  logic             cs_ok;
  logic             start;
  logic             acc_go;
  logic             adv_go;
  op_e              op_q;
  logic [LANES-1:0] wmask_q;
  logic [DW-1:0]    wdata_q;
  logic [AW-1:0]    base_q;
  logic [1:0]       cnt_q;
  logic [AW-1:0]    eff_addr;

  assign cs_ok = !sel_a_n && sel_b && !sel_c_n;

  pbsram_cmd #(.DW(DW), .LANES(LANES)) cmd_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_cpu_n  (start_cpu_n),
    .start_ctl_n  (start_ctl_n),
    .burst_adv_n  (burst_adv_n),
    .cs_ok        (cs_ok),
    .wr_all_n     (wr_all_n),
    .wr_byte_en_n (wr_byte_en_n),
    .wr_lane_n    (wr_lane_n),
    .dq_i         (dq_i),
    .start        (start),
    .acc_go       (acc_go),
    .adv_go       (adv_go),
    .op_q         (op_q),
    .wmask_q      (wmask_q),
    .wdata_q      (wdata_q)
  );

  pbsram_burst #(.AW(AW)) burst_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acc_go),
    .step     (adv_go),
    .ilv      (burst_ilv),
    .addr     (addr),
    .base_q   (base_q),
    .cnt_q    (cnt_q),
    .eff_addr (eff_addr)
  );

  pbsram_array #(.DEPTH(DEPTH), .DW(DW)) array_i (
    .clk   (clk),
    .we    (op_q == OP_WR),
    .re    (op_q == OP_RD),
    .addr  (eff_addr),
    .wmask (wmask_q),
    .wdata (wdata_q),
    .rd_q  (dq_o)
  );

  pbsram_out out_i (
    .clk   (clk),
    .rst_n (rst_n),
    .op_q  (op_q),
    .oe_n  (oe_n),
    .dq_en (dq_en)
  );

endmodule

// File: rtl/pbsram_chk.sv
module pbsram_chk
  import pbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe_n,
  input logic          dq_en,
  input op_e           op_q,
  input logic          start,
  input logic          cs_ok,
  input logic          adv_go,
  input logic [1:0]    cnt_q,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] addr
);

  always_comb begin
    if (rst_n && oe_n) begin
      assert_oe_off_R5: assert (!dq_en) else $error("bus driven with oe_n high");
    end
  end

  assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_RD) |=> !dq_en);

  assert_desel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cs_ok) |=> (op_q == OP_NONE));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cs_ok) |=> (cnt_q == 2'd0 && base_q == $past(addr)));

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adv_go |=> (cnt_q == $past(cnt_q) + 2'd1));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(start && cs_ok) && !adv_go) |=> ($stable(cnt_q) && $stable(base_q)));

endmodule

bind pbsram_core pbsram_chk #(.AW(AW)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .oe_n   (oe_n),
  .dq_en  (dq_en),
  .op_q   (op_q),
  .start  (start),
  .cs_ok  (cs_ok),
  .adv_go (adv_go),
  .cnt_q  (cnt_q),
  .base_q (base_q),
  .addr   (addr)
);

// File: tb/pbsram_core_tb_top.sv
module pbsram_core_tb_top;

  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [2:0] CS_ON  = 3'b010; // {sel_a_n, sel_b, sel_c_n}
  localparam logic [2:0] CS_OFF = 3'b110;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1, ilv = 1'b0;
  logic          gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]    lane_n = 4'hF;
  logic          sa_n = 1'b1, sb = 1'b0, sc_n = 1'b1;
  logic          oe_n = 1'b0;
  logic [31:0]   dq_i = '0;
  logic [31:0]   dq_o;
  logic          dq_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0]   mdl [DEPTH];
  bit            m_sel = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  bit            p_rd = 0;
  logic [31:0]   p_data = '0;
  string         p_tag = "R6";

  always #4 clk = ~clk;

  pbsram_core #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .start_cpu_n(cpu_n), .start_ctl_n(ctl_n), .burst_adv_n(adv_n), .burst_ilv(ilv),
    .wr_all_n(gw_n), .wr_byte_en_n(bwe_n), .wr_lane_n(lane_n),
    .sel_a_n(sa_n), .sel_b(sb), .sel_c_n(sc_n), .oe_n(oe_n),
    .dq_i(dq_i), .dq_o(dq_o), .dq_en(dq_en)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] eaddr(input logic [AW-1:0] b, input logic [1:0] n, input logic iv);
    logic [1:0] lo;
    lo = iv ? (b[1:0] ^ n) : (b[1:0] + n);
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [31:0] pat(input int a);
    return {8'hA5, a[7:0], ~a[7:0], a[7:0] ^ 8'h3C};
  endfunction

  // Model one command, clock it, then check the output of the previous one.
  task automatic tick(input string tag);
    bit st, cs, wr_any, rd;
    logic [3:0] m;
    logic [AW-1:0] a;
    logic [31:0] ed;
    int op;
    rd = 0; ed = '0; op = 0;
    st = !cpu_n || !ctl_n;
    cs = !sa_n && sb && !sc_n;
    m = !gw_n ? 4'hF : (!bwe_n ? ~lane_n : 4'h0);
    wr_any = (m != 4'h0);
    if (st) begin
      m_sel = cs;
      if (cs) begin
        m_base = addr; m_cnt = 2'd0;
        op = !cpu_n ? 1 : (wr_any ? 2 : 1);
      end
    end else if (m_sel) begin
      if (!adv_n) m_cnt = m_cnt + 2'd1;
      op = wr_any ? 2 : 1;
    end
    a = eaddr(m_base, m_cnt, ilv);
    if (op == 2) begin
      for (int l = 0; l < 4; l++)
        if (m[l]) mdl[a][l*8 +: 8] = dq_i[l*8 +: 8];
    end else if (op == 1) begin
      rd = 1; ed = mdl[a];
    end
    @(posedge clk);
    @(negedge clk);
    chk(dq_en === (p_rd && !oe_n), {p_tag, " enable"}, {31'd0, dq_en}, {31'd0, p_rd && !oe_n});
    if (p_rd && !oe_n) chk(dq_o === p_data, {p_tag, " data"}, dq_o, p_data);
    p_rd = rd; p_data = ed; p_tag = tag;
  endtask

  task automatic cmd(input bit cpu, input bit ctl, input bit adv, input bit gw, input bit bwe,
                     input logic [3:0] ln, input logic [2:0] cs3, input logic [AW-1:0] a,
                     input logic [31:0] d, input string tag);
    cpu_n = cpu; ctl_n = ctl; adv_n = adv; gw_n = gw; bwe_n = bwe; lane_n = ln;
    {sa_n, sb, sc_n} = cs3; addr = a; dq_i = d;
    tick(tag);
  endtask

  task automatic desel(input string tag);
    cmd(1, 0, 1, 1, 1, 4'hF, CS_OFF, '0, '0, tag);
  endtask

  task automatic rd_start(input logic [AW-1:0] a, input string tag);
    cmd(1, 0, 1, 1, 1, 4'hF, CS_ON, a, '0, tag);
  endtask

  task automatic rd_next(input bit adv, input string tag);
    cmd(1, 1, adv, 1, 1, 4'hF, CS_ON, '0, '0, tag);
  endtask

  task automatic rand_phase(input int n);
    logic [2:0] cs3;
    for (int i = 0; i < n; i++) begin
      cs3 = ($urandom % 10 == 0) ? 3'($urandom) : CS_ON;
      cmd(($urandom % 6) != 0, ($urandom % 5) != 0, 1'($urandom), ($urandom % 8) != 0,
          1'($urandom), 4'($urandom), cs3, AW'($urandom), $urandom, "R1 random");
    end
    desel("R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(dq_en === 1'b0, "R12 reset", {31'd0, dq_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dq_en === 1'b0, "R12 after reset", {31'd0, dq_en}, 32'd0);

    // Fill the array with a global write per word (R3).
    for (int a = 0; a < DEPTH; a++)
      cmd(1, 0, 1, 0, 1, 4'hF, CS_ON, AW'(a), pat(a), "R3");
    desel("R6 masked after write");

    // R1 / R6: read after deselect, then continuation.
    rd_start(8'h05, "R1 read latency");
    rd_next(1, "R10 repeat address");
    // R5: asynchronous output enable while read data is live.
    oe_n = 1'b1; #1;
    chk(dq_en === 1'b0, "R5 oe high", {31'd0, dq_en}, 32'd0);
    oe_n = 1'b0; #1;
    chk(dq_en === 1'b1, "R5 oe low", {31'd0, dq_en}, 32'd1);
    desel("R6");

    // R2: byte write to lanes 0 and 2, then R11 immediate read-back.
    cmd(1, 0, 1, 1, 0, 4'b1010, CS_ON, 8'h07, 32'h11223344, "R2");
    rd_start(8'h07, "R2 R11 lanes 0,2 merged");
    desel("R6");

    // R3: global write overrides disabled byte controls.
    cmd(1, 0, 1, 0, 1, 4'hF, CS_ON, 8'h08, 32'hCAFEF00D, "R3");
    rd_start(8'h08, "R3 global write");

    // R7: processor strobe with write controls active still reads.
    cmd(0, 1, 1, 0, 0, 4'h0, CS_ON, 8'h09, 32'hDEADBEEF, "R7 cpu strobe reads");
    rd_next(1, "R7 no write");

    // R4: write attempt while deselected, then continuation ignored.
    cmd(1, 0, 1, 0, 1, 4'hF, 3'b000, 8'h0A, 32'h0BADF00D, "R4");
    cmd(1, 1, 0, 0, 1, 4'hF, CS_ON, 8'h0A, 32'h0BADF00D, "R4 continuation ignored");
    rd_start(8'h0A, "R4 word unchanged");
    desel("R6");

    // R8: linear burst from offset 1 with wrap.
    ilv = 1'b0;
    rd_start(8'h21, "R8 start");
    rd_next(0, "R8 step1 0x22");
    rd_next(0, "R8 step2 0x23");
    rd_next(0, "R8 step3 0x20");
    rd_next(0, "R8 wrap 0x21");
    desel("R6");

    // R9: interleaved bursts from offsets 2 and 1.
    ilv = 1'b1;
    rd_start(8'h32, "R9 start");
    rd_next(0, "R9 0x33");
    rd_next(0, "R9 0x30");
    rd_next(0, "R9 0x31");
    rd_start(8'h41, "R9 start");
    rd_next(0, "R9 0x40");
    rd_next(0, "R9 0x43");
    rd_next(0, "R9 0x42");
    // R10: writes during continuation, then read back.
    cmd(1, 1, 0, 0, 1, 4'hF, CS_ON, '0, 32'h5555AAAA, "R10 write on advance");
    cmd(1, 1, 1, 1, 0, 4'b0111, CS_ON, '0, 32'h77000000, "R10 write in place");
    rd_next(1, "R10 R11 read back");
    desel("R6");

    ilv = 1'b0;
    rand_phase(1500);
    ilv = 1'b1;
    rand_phase(1500);
    desel("R6");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule